// File: doc/BRIEF.md
# Instruction Fetch Sequencer

This block fetches one whole instruction of a 16-bit two-address instruction set from a program memory that is only one byte wide. A rising start request latches a program counter. The block then reads bytes at ascending addresses and pairs them into 16-bit words, placing the byte at the lower address in the low half. It decodes the first word to find how many extension words follow: zero, one or two. When the last word has arrived, it presents the opcode word and its extension words, raises a one-cycle valid strobe and reports the address just past the instruction.

Each word costs three cycles. The first cycle drives the low-byte address, the second captures the low byte and drives the high-byte address, and the third joins the two bytes and decides whether another word is needed. The memory returns data one cycle after it sees a read strobe. A start request is only honoured while the sequencer is idle.

Top module: `ifetch_seq`

## Requirements
- R1: After reset, valid, busy and the read strobe are low, and the opcode, both extension words, the word count and the next address are all zero.
- R2: Each 16-bit word is formed with the byte from the even (lower) address in bits 7:0 and the byte from the following address in bits 15:8.
- R3: For a two-operand opcode (bits 15:12 at 4 or higher), the source field is As in bits 5:4 with its register in bits 11:8, and Ad in bit 7 selects a destination extension. The sequence 40B2 5A80 0120 gives three words, and 43C2 0021 gives two.
- R4: A source As value of 01 or 11 adds one extension word, except when the source register is 3 (any As) or register 2 with As 10 or 11. Those constant encodings add none.
- R5: An opcode with bits 15:10 equal to 000100 is single-operand, with As in bits 5:4 and its register in bits 3:0, under the rule of R4. An opcode with bits 15:13 equal to 001 is a jump and is always one word.
- R6: Extension words appear in memory order. The source extension, when present, is in the first extension slot, and the destination extension follows it.
- R7: If start is sampled at rising edge 0, valid is high from edge 3n to edge 3n+1 only, where n is the word count.
- R8: While valid is high, the word count output equals n (1 to 3) and the next address equals the start address plus 2n, modulo the address width.
- R9: Extension slots not used by the instruction read as zero while valid is high.
- R10: A start request while busy is ignored, and so are changes of the PC input during a fetch. A start held high through valid launches the next fetch from the PC input sampled one cycle after valid.
- R11: Byte reads go to consecutive ascending addresses and wrap from the top of the address space to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a fetch when idle |
| pc_i | input | AW | Byte address of the instruction |
| mem_addr_o | output | AW | Byte read address |
| mem_rd_o | output | 1 | Read strobe; data returns next cycle |
| mem_data_i | input | 8 | Read data byte |
| busy_o | output | 1 | Fetch in progress |
| valid_o | output | 1 | One-cycle strobe: instruction ready |
| opcode_o | output | 16 | First instruction word |
| ext1_o | output | 16 | First extension word or zero |
| ext2_o | output | 16 | Second extension word or zero |
| nwords_o | output | 2 | Instruction length in words |
| next_pc_o | output | AW | Address after the instruction |

## Verification
Two things can fall in the same cycle. The valid strobe of one fetch can coincide with a start request already present for the next one, and a start request can arrive at a moment when a fetch is still running. The bench holds start high through a complete fetch and changes the PC input partway through. It then checks that the result still comes from the first address and that a new fetch begins from the updated PC exactly two cycles after the valid cycle, with the expected latency. Corner cases are the constant encodings that look as if they need an extension word, jump words whose low bits imitate an immediate operand, and an instruction that straddles the top of the address space.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
    localparam int unsigned IW    = 16;
    localparam int unsigned BW    = 8;
    localparam int unsigned NSLOT = 3;
    localparam int unsigned CW    = 2;

    typedef enum logic [2:0] {
        F_IDLE = 3'd0,
        F_LO   = 3'd1,
        F_HI   = 3'd2,
        F_DEC  = 3'd3,
        F_DONE = 3'd4
    } fstate_e;
endpackage

// File: rtl/ifetch_len_dec.sv
module ifetch_len_dec
    import ifetch_pkg::*;
(
    input  logic [IW-1:0] word_i,
    output logic [CW-1:0] ext_cnt_o
);
    logic       is_jump, is_one, is_two;
    logic [1:0] as_f;
    logic [3:0] src_reg;
    logic       src_ext, dst_ext;

    function automatic logic src_needs_ext(input logic [1:0] as_v, input logic [3:0] r);
        // As 01/11 need a word; register 3 and register 2 with As 1x are constants
        return as_v[0] && (r != 4'd3) && !((r == 4'd2) && as_v[1]);
    endfunction

    always_comb begin
        is_jump = (word_i[15:13] == 3'b001);
        is_one  = (word_i[15:10] == 6'b000100);
        is_two  = (word_i[15:12] >= 4'h4);
        as_f    = word_i[5:4];
        src_reg = is_two ? word_i[11:8] : word_i[3:0];
        src_ext = 1'b0;
        dst_ext = 1'b0;
        if (is_two) begin
            src_ext = src_needs_ext(as_f, src_reg);
            dst_ext = word_i[7];
        end else if (is_one && !is_jump) begin
            src_ext = src_needs_ext(as_f, src_reg);
        end
        ext_cnt_o = CW'(src_ext) + CW'(dst_ext);
    end
endmodule

// File: rtl/ifetch_slot_bank.sv
module ifetch_slot_bank #(
    parameter int unsigned NSLOTS = 3,
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned IDXW   = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    we_i,
    input  logic [IDXW-1:0]         idx_i,
    input  logic [WIDTH-1:0]        data_i,
    output logic [NSLOTS*WIDTH-1:0] slots_o
);
    for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
        logic [WIDTH-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (clr_i)
                slot_d = '0;
            else if (we_i && (idx_i == IDXW'(g)))
                slot_d = data_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign slots_o[g*WIDTH +: WIDTH] = slot_q;
    end
endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
    import ifetch_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] pc_i,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_rd_o,
    input  logic [BW-1:0] mem_data_i,
    output logic          busy_o,
    output logic          valid_o,
    output logic [IW-1:0] opcode_o,
    output logic [IW-1:0] ext1_o,
    output logic [IW-1:0] ext2_o,
    output logic [CW-1:0] nwords_o,
    output logic [AW-1:0] next_pc_o
);
    localparam int unsigned IDXW = $clog2(NSLOT);

    typedef struct packed {
        fstate_e       st;
        logic [AW-1:0] addr;
        logic          rd;
        logic [AW-1:0] base;
        logic [BW-1:0] lo;
        logic [IDXW-1:0] idx;
        logic [CW-1:0] total;
        logic [CW-1:0] n;
        logic [AW-1:0] npc;
    } seq_t;

    seq_t r_d, r_q;

    logic [IW-1:0]       word_now;
    logic [CW-1:0]       ext_cnt;
    logic [CW-1:0]       tot_now;
    logic [IDXW-1:0]     idx_nx;
    logic                slot_clr, slot_we;
    logic [NSLOT*IW-1:0] slots;

    assign word_now = {mem_data_i, r_q.lo};

    ifetch_len_dec u_len (
        .word_i    (word_now),
        .ext_cnt_o (ext_cnt)
    );

    ifetch_slot_bank #(.NSLOTS(NSLOT), .WIDTH(IW), .IDXW(IDXW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (slot_clr),
        .we_i    (slot_we),
        .idx_i   (r_q.idx),
        .data_i  (word_now),
        .slots_o (slots)
    );

    always_comb begin
        r_d      = r_q;
        slot_clr = 1'b0;
        slot_we  = 1'b0;
        idx_nx   = r_q.idx + IDXW'(1);
        tot_now  = (r_q.idx == '0) ? (ext_cnt + CW'(1)) : r_q.total;
        unique case (r_q.st)
            F_IDLE: begin
                if (start_i) begin
                    r_d.st   = F_LO;
                    r_d.addr = pc_i;
                    r_d.base = pc_i;
                    r_d.rd   = 1'b1;
                    r_d.idx  = '0;
                    slot_clr = 1'b1;
                end
            end
            F_LO: begin
                r_d.addr = r_q.addr + AW'(1);
                r_d.rd   = 1'b1;
                r_d.st   = F_HI;
            end
            F_HI: begin
                r_d.lo = mem_data_i;
                r_d.rd = 1'b0;
                r_d.st = F_DEC;
            end
            F_DEC: begin
                slot_we   = 1'b1;
                r_d.total = tot_now;
                if (CW'(idx_nx) < tot_now) begin
                    r_d.idx  = idx_nx;
                    r_d.addr = r_q.addr + AW'(1);
                    r_d.rd   = 1'b1;
                    r_d.st   = F_LO;
                end else begin
                    r_d.n   = CW'(idx_nx);
                    r_d.npc = r_q.addr + AW'(1);
                    r_d.st  = F_DONE;
                end
            end
            F_DONE: begin
                r_d.st = F_IDLE;
            end
            default: r_d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: F_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr_o = r_q.addr;
    assign mem_rd_o   = r_q.rd;
    assign busy_o     = (r_q.st != F_IDLE);
    assign valid_o    = (r_q.st == F_DONE);
    assign opcode_o   = slots[0*IW +: IW];
    assign ext1_o     = slots[1*IW +: IW];
    assign ext2_o     = slots[2*IW +: IW];
    assign nwords_o   = r_q.n;
    assign next_pc_o  = r_q.npc;

    // R7: the completion strobe lasts a single cycle
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: length is never zero at completion
    p_len_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (nwords_o != '0));

    // R8: next address agrees with the latched start address and the count
    p_next_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (next_pc_o == r_q.base + AW'({nwords_o, 1'b0})));

    // R9: slots beyond the length are zero
    p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && (nwords_o == CW'(1))) |-> ((ext1_o == '0) && (ext2_o == '0)));

    p_unused_ext2_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && (nwords_o == CW'(2))) |-> (ext2_o == '0));

    // R11: back-to-back reads step by one byte
    p_addr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == AW'($past(mem_addr_o) + AW'(1))));

    // R10: the latched start address does not move during a fetch
    p_base_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_o) && busy_o) |-> $stable(r_q.base));
endmodule

// File: tb/sim_ifetch_seq.sv
module sim_ifetch_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] pc = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic [7:0]    mem_q = 8'h00;
    logic          busy, valid;
    logic [15:0]   opcode, ext1, ext2;
    logic [1:0]    nwords;
    logic [AW-1:0] next_pc;
    logic [7:0]    mem [0:255];

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (mem_rd) mem_q <= mem[mem_addr[7:0]];

    ifetch_seq #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .pc_i(pc),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_data_i(mem_q),
        .busy_o(busy), .valid_o(valid), .opcode_o(opcode),
        .ext1_o(ext1), .ext2_o(ext2), .nwords_o(nwords), .next_pc_o(next_pc)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic put_word(input logic [7:0] a, input logic [15:0] w);
        mem[a]         = w[7:0];
        mem[a + 8'd1]  = w[15:8];
    endtask

    task automatic wait_valid(output int k);
        k = 1;
        while (!valid && k < 60) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic fetch(input logic [15:0] a, input int n, input logic [15:0] op,
                         input logic [15:0] e1, input logic [15:0] e2, input string rq);
        int k;
        @(negedge clk);
        pc = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_valid(k);
        chk("R7", "latency", k, 3*n + 1);
        chk(rq, "opcode", opcode, op);
        chk(rq, "ext1", ext1, e1);
        chk(rq, "ext2", ext2, e2);
        chk("R8", "nwords", nwords, n);
        chk("R8", "next_pc", next_pc, 32'(16'(a + 16'(2*n))));
        @(negedge clk);
        chk("R7", "valid single cycle", valid, 0);
    endtask

    task automatic t_reset();
        chk("R1", "valid", valid, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "rd", mem_rd, 0);
        chk("R1", "opcode", opcode, 0);
        chk("R1", "ext", {ext1, ext2}, 0);
        chk("R1", "nwords/next_pc", {nwords, next_pc}, 0);
    endtask

    task automatic t_two_operand();
        fetch(16'h0010, 3, 16'h40B2, 16'h5A80, 16'h0120, "R3");
        fetch(16'h0020, 2, 16'h43C2, 16'h0021, 16'h0000, "R3");
    endtask

    task automatic t_constgen();
        fetch(16'h0030, 1, 16'h4232, 16'h0000, 16'h0000, "R4");
        fetch(16'h0034, 2, 16'h4215, 16'h1111, 16'h0000, "R4");
        fetch(16'h0070, 2, 16'hD3E2, 16'h0021, 16'h0000, "R4");
    endtask

    task automatic t_order();
        fetch(16'h003A, 3, 16'h4495, 16'hAAAA, 16'hBBBB, "R6");
    endtask

    task automatic t_unused();
        fetch(16'h003A, 3, 16'h4495, 16'hAAAA, 16'hBBBB, "R9");
        fetch(16'h0030, 1, 16'h4232, 16'h0000, 16'h0000, "R9");
    endtask

    task automatic t_endian();
        mem[8'h40] = 8'h05; mem[8'h41] = 8'h44;
        fetch(16'h0040, 1, 16'h4405, 16'h0000, 16'h0000, "R2");
    endtask

    task automatic t_single_jump();
        fetch(16'h0050, 2, 16'h1230, 16'hBEEF, 16'h0000, "R5");
        fetch(16'h0054, 1, 16'h1005, 16'h0000, 16'h0000, "R5");
        fetch(16'h0058, 2, 16'h1294, 16'h0042, 16'h0000, "R5");
        fetch(16'h005C, 1, 16'h12B3, 16'h0000, 16'h0000, "R5");
        fetch(16'h0060, 1, 16'h3C05, 16'h0000, 16'h0000, "R5");
        fetch(16'h0064, 1, 16'h2430, 16'h0000, 16'h0000, "R5");
    endtask

    task automatic t_busy_start();
        int k;
        @(negedge clk);
        pc = 16'h0010; start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        pc = 16'h0020;
        k = 2;
        while (!valid && k < 60) begin
            @(negedge clk);
            k++;
        end
        chk("R10", "latency with start held", k, 10);
        chk("R10", "opcode from first pc", opcode, 16'h40B2);
        chk("R10", "next_pc from first pc", next_pc, 16'h0016);
        pc = 16'h0040;
        @(negedge clk);
        chk("R10", "no restart on valid", valid, 0);
        k = 1;
        while (!valid && k < 60) begin
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        chk("R10", "relaunch latency", k, 5);
        chk("R10", "relaunch opcode", opcode, 16'h4405);
        chk("R10", "relaunch next_pc", next_pc, 16'h0042);
        @(negedge clk);
    endtask

    task automatic t_wrap();
        fetch(16'hFFFE, 2, 16'h4035, 16'h1234, 16'h0000, "R11");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        put_word(8'h00, 16'h1234);
        put_word(8'hFE, 16'h4035);
        put_word(8'h10, 16'h40B2); put_word(8'h12, 16'h5A80); put_word(8'h14, 16'h0120);
        put_word(8'h20, 16'h43C2); put_word(8'h22, 16'h0021);
        put_word(8'h30, 16'h4232);
        put_word(8'h34, 16'h4215); put_word(8'h36, 16'h1111);
        put_word(8'h3A, 16'h4495); put_word(8'h3C, 16'hAAAA); put_word(8'h3E, 16'hBBBB);
        put_word(8'h42, 16'h1234);
        put_word(8'h50, 16'h1230); put_word(8'h52, 16'hBEEF);
        put_word(8'h54, 16'h1005);
        put_word(8'h58, 16'h1294); put_word(8'h5A, 16'h0042);
        put_word(8'h5C, 16'h12B3);
        put_word(8'h60, 16'h3C05); put_word(8'h62, 16'h4444);
        put_word(8'h64, 16'h2430); put_word(8'h66, 16'h5555);
        put_word(8'h70, 16'hD3E2); put_word(8'h72, 16'h0021);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_endian();
        t_two_operand();
        t_constgen();
        t_order();
        t_unused();
        t_single_jump();
        t_busy_start();
        t_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule